// File: doc/BRIEF.md
# Smart Card Session Sequencer

This block is the control engine for a contact smart card slot. A host asks for a session by pulling an active-low request low. The block then powers the card in a fixed order: converter, card supply, data lines and clock, and finally the reset release. It keeps the slot live until the host ends the session, mode drops to sleep, or a fault appears. It then removes power in the reverse order and returns to idle or low-power. The block itself has no notion of time. All step timing counts pulses on `halfTick`, and each pulse marks one half of the 25 µs base period T.

A fault is any of overcurrent, overheat, supply low or a missing card. A fault during power-up or a live session pulls the open-drain interrupt low and runs the same shutdown. The interrupt stays pending until the host has withdrawn its request while a card is seated, and no new session can start while it is pending. Several slots can share control wires: while `chipSel` is low, each block freezes its view of the control inputs and stops driving its interrupt.

Top module: `card_session_seq`

## Requirements
- R1: After reset all card-side enables and `cardRst` are 0 and `irqLowEn` is 0.
- R2: From idle, a session starts when `modeNormal` is 1, `sessReqN` is 0 and no interrupt is pending: `convEn` rises on that clock edge. No session can start while `modeNormal` is 0.
- R3: During power-up, counting `halfTick` pulses from the converter start: `supplyEn` rises on pulse 3 and `dataEn` rises on pulse 8. Reset is enabled on pulse 14, and the slot is then live.
- R4: `clkEn` rises on the first edge at which `rstReq` is 1 while the power-up count is between 8 and 13. Once reset is enabled, `rstReq` no longer changes `clkEn`.
- R5: While reset is enabled, `cardRst` equals the inverse of `rstReq`, one clock later. Otherwise it is 0.
- R6: With the slot live, `sessReqN`=1 or `modeNormal`=0 starts a shutdown. `cardRst` drops on the entry edge. `clkEn` falls on pulse 1, `dataEn` on pulse 2, `supplyEn` on pulse 3 and `convEn` on pulse 10, after which the block is idle.
- R7: A shutdown caused by `modeNormal`=0 ends in low-power. Leaving low-power takes WAKE_TICKS consecutive `halfTick` pulses with `modeNormal`=1. Any 0 in between restarts the count.
- R8: Any fault flag, or `cardPresent`=0, seen during power-up or a live session sets the interrupt and runs the R6 shutdown timing. The block then ends in idle.
- R9: A pending interrupt clears only in idle or low-power, when `sessReqN`=1 and `cardPresent`=1. While it is pending, no session starts.
- R10: While `chipSel` is 0, the block acts on the `sessReqN`, `modeNormal` and `rstReq` values last sampled with `chipSel`=1, and `irqLowEn` is 0.
- R11: A new session request that arrives during a shutdown does not alter it. The new session starts only once idle is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sessReqN | input | 1 | Session request, active low |
| modeNormal | input | 1 | 1 = normal operation, 0 = sleep |
| rstReq | input | 1 | Reset request; gates the clock during power-up, drives `cardRst` inverted afterwards |
| cardPresent | input | 1 | 1 when a card is seated |
| faultOvercurrent | input | 1 | Card supply overcurrent flag |
| faultOverheat | input | 1 | Overtemperature flag |
| faultSupplyLow | input | 1 | Host supply undervoltage flag |
| chipSel | input | 1 | 1 = inputs live and interrupt driven; 0 = inputs frozen, interrupt released |
| halfTick | input | 1 | One-cycle pulse every T/2 |
| convEn | output | 1 | Step-up converter enable |
| supplyEn | output | 1 | Card supply enable |
| dataEn | output | 1 | Data lines released (0 forces them low) |
| clkEn | output | 1 | Card clock enable |
| cardRst | output | 1 | Card reset level |
| irqLowEn | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
Checked on every cycle: the nesting of the enables, where the supply needs the converter, the data lines need the supply and a raised reset needs the data lines. Also checked every cycle: a fault in power-up or a live session always leads to the fault shutdown; a pending interrupt or low-power never leads straight into power-up; and a shutdown never jumps back to a live state. The exact pulse counts of each step, the clock window around `rstReq`, the low-power wake count, the interrupt release rules and the chip-select freeze show only in the bench's scenarios. There a behavioural model runs beside the design and is compared with it on every clock.

// File: rtl/scs_pkg.sv
package scs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLEEP,
    ST_RAMP,
    ST_LIVE,
    ST_DOWN,
    ST_TRIP
  } seqState_t;

  // set/clear strobes from control to the output registers
  typedef struct packed {
    logic convOn;
    logic convOff;
    logic supplyOn;
    logic supplyOff;
    logic dataOn;
    logic dataOff;
    logic clkStart;
    logic clkOff;
    logic rstArm;
    logic rstDrop;
    logic irqSet;
    logic irqClear;
  } strobes_t;

  // step positions in half base periods
  localparam int unsigned DEF_SUP_ON   = 3;
  localparam int unsigned DEF_IO_ON    = 8;
  localparam int unsigned DEF_RST_ON   = 14;
  localparam int unsigned DEF_CLK_OFF  = 1;
  localparam int unsigned DEF_IO_OFF   = 2;
  localparam int unsigned DEF_SUP_OFF  = 3;
  localparam int unsigned DEF_CONV_OFF = 10;
  localparam int unsigned DEF_WAKE     = 96;

endpackage

// File: rtl/scs_dp.sv
module scs_dp
  import scs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sessReqN,
  input  logic     modeNormal,
  input  logic     rstReq,
  input  logic     chipSel,
  input  logic     cardPresent,
  input  logic     faultOvercurrent,
  input  logic     faultOverheat,
  input  logic     faultSupplyLow,
  input  strobes_t stb,
  output logic     effReqN,
  output logic     effMode,
  output logic     effRstReq,
  output logic     faultAny,
  output logic     irqPend,
  output logic     convEn,
  output logic     supplyEn,
  output logic     dataEn,
  output logic     clkEn,
  output logic     cardRst,
  output logic     irqLowEn
);

  logic heldReqN, heldMode, heldRstReq;
  logic rstArmed;

  // input freeze while deselected
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldReqN   <= 1'b1;
      heldMode   <= 1'b1;
      heldRstReq <= 1'b0;
    end else if (chipSel) begin
      heldReqN   <= sessReqN;
      heldMode   <= modeNormal;
      heldRstReq <= rstReq;
    end
  end

  assign effReqN   = chipSel ? sessReqN   : heldReqN;
  assign effMode   = chipSel ? modeNormal : heldMode;
  assign effRstReq = chipSel ? rstReq     : heldRstReq;
  assign faultAny  = faultOvercurrent | faultOverheat | faultSupplyLow | ~cardPresent;

  // card-side output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convEn   <= 1'b0;
      supplyEn <= 1'b0;
      dataEn   <= 1'b0;
      clkEn    <= 1'b0;
      rstArmed <= 1'b0;
      cardRst  <= 1'b0;
      irqPend  <= 1'b0;
    end else begin
      if (stb.convOn)        convEn <= 1'b1;
      else if (stb.convOff)  convEn <= 1'b0;

      if (stb.supplyOn)       supplyEn <= 1'b1;
      else if (stb.supplyOff) supplyEn <= 1'b0;

      if (stb.dataOn)         dataEn <= 1'b1;
      else if (stb.dataOff)   dataEn <= 1'b0;

      if (stb.clkStart)       clkEn <= 1'b1;
      else if (stb.clkOff)    clkEn <= 1'b0;

      if (stb.rstDrop) begin
        rstArmed <= 1'b0;
        cardRst  <= 1'b0;
      end else if (stb.rstArm || rstArmed) begin
        rstArmed <= 1'b1;
        cardRst  <= ~effRstReq;
      end

      if (stb.irqSet)        irqPend <= 1'b1;
      else if (stb.irqClear) irqPend <= 1'b0;
    end
  end

  assign irqLowEn = irqPend & chipSel;

  a_r3_supply_under_conv: assert property (@(posedge clk) disable iff (!rstN)
    supplyEn |-> convEn);
  a_r3_data_under_supply: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> supplyEn);
  a_r5_rst_under_data: assert property (@(posedge clk) disable iff (!rstN)
    cardRst |-> dataEn);
  a_r6_clk_gone_with_supply: assert property (@(posedge clk) disable iff (!rstN)
    $fell(supplyEn) |-> !clkEn);

endmodule

// File: rtl/scs_ctrl.sv
module scs_ctrl
  import scs_pkg::*;
#(
  parameter int unsigned SUP_ON     = DEF_SUP_ON,
  parameter int unsigned IO_ON      = DEF_IO_ON,
  parameter int unsigned RST_ON     = DEF_RST_ON,
  parameter int unsigned CLK_OFF    = DEF_CLK_OFF,
  parameter int unsigned IO_OFF     = DEF_IO_OFF,
  parameter int unsigned SUP_OFF    = DEF_SUP_OFF,
  parameter int unsigned CONV_OFF   = DEF_CONV_OFF,
  parameter int unsigned WAKE_TICKS = DEF_WAKE
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     effReqN,
  input  logic     effMode,
  input  logic     effRstReq,
  input  logic     faultAny,
  input  logic     cardPresent,
  input  logic     irqPend,
  input  logic     halfTick,
  output strobes_t stb
);

  localparam int unsigned STEP_MAX = (RST_ON > CONV_OFF) ? RST_ON : CONV_OFF;
  localparam int unsigned STEP_W   = $clog2(STEP_MAX + 1);
  localparam int unsigned WAKE_W   = $clog2(WAKE_TICKS + 1);

  seqState_t           state, stateNxt;
  logic [STEP_W-1:0]   step, stepNxt, stepInc;
  logic [WAKE_W-1:0]   wake, wakeNxt, wakeInc;
  logic                stopReq;

  assign stepInc = step + 1'b1;
  assign wakeInc = wake + 1'b1;
  assign stopReq = effReqN | ~effMode;

  always_comb begin
    stateNxt = state;
    stepNxt  = step;
    wakeNxt  = wake;
    stb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (!effMode) begin
          stateNxt = ST_SLEEP;
          wakeNxt  = '0;
        end else if (!effReqN && !irqPend) begin
          stateNxt   = ST_RAMP;
          stepNxt    = '0;
          stb.convOn = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (!effMode) begin
          wakeNxt = '0;
        end else if (halfTick) begin
          wakeNxt = wakeInc;
          if (wakeInc == WAKE_W'(WAKE_TICKS)) stateNxt = ST_IDLE;
        end
      end
      ST_RAMP, ST_LIVE: begin
        if (faultAny) begin
          stb.irqSet  = 1'b1;
          stb.rstDrop = 1'b1;
          stateNxt    = ST_TRIP;
          stepNxt     = '0;
        end else if (stopReq) begin
          stb.rstDrop = 1'b1;
          stateNxt    = ST_DOWN;
          stepNxt     = '0;
        end else if (state == ST_RAMP) begin
          if (step >= STEP_W'(IO_ON) && effRstReq) stb.clkStart = 1'b1;
          if (halfTick) begin
            stepNxt = stepInc;
            if (stepInc == STEP_W'(SUP_ON)) stb.supplyOn = 1'b1;
            if (stepInc == STEP_W'(IO_ON))  stb.dataOn   = 1'b1;
            if (stepInc == STEP_W'(RST_ON)) begin
              stb.rstArm = 1'b1;
              stateNxt   = ST_LIVE;
            end
          end
        end
      end
      ST_DOWN, ST_TRIP: begin
        if (halfTick) begin
          stepNxt = stepInc;
          if (stepInc == STEP_W'(CLK_OFF)) stb.clkOff    = 1'b1;
          if (stepInc == STEP_W'(IO_OFF))  stb.dataOff   = 1'b1;
          if (stepInc == STEP_W'(SUP_OFF)) stb.supplyOff = 1'b1;
          if (stepInc == STEP_W'(CONV_OFF)) begin
            stb.convOff = 1'b1;
            wakeNxt     = '0;
            stateNxt    = (state == ST_DOWN && !effMode) ? ST_SLEEP : ST_IDLE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
    if ((state == ST_IDLE || state == ST_SLEEP) && effReqN && cardPresent)
      stb.irqClear = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= '0;
      wake  <= '0;
    end else begin
      state <= stateNxt;
      step  <= stepNxt;
      wake  <= wakeNxt;
    end
  end

  a_r2_no_ramp_from_sleep: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SLEEP |=> state != ST_RAMP);
  a_r8_fault_trips: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RAMP || state == ST_LIVE) && faultAny) |=> state == ST_TRIP);
  a_r9_pending_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && irqPend) |=> state != ST_RAMP);
  a_r11_down_runs_out: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DOWN |=> (state == ST_DOWN || state == ST_IDLE || state == ST_SLEEP));

endmodule

// File: rtl/card_session_seq.sv
module card_session_seq
  import scs_pkg::*;
#(
  parameter int unsigned SUP_ON     = DEF_SUP_ON,
  parameter int unsigned IO_ON      = DEF_IO_ON,
  parameter int unsigned RST_ON     = DEF_RST_ON,
  parameter int unsigned CLK_OFF    = DEF_CLK_OFF,
  parameter int unsigned IO_OFF     = DEF_IO_OFF,
  parameter int unsigned SUP_OFF    = DEF_SUP_OFF,
  parameter int unsigned CONV_OFF   = DEF_CONV_OFF,
  parameter int unsigned WAKE_TICKS = DEF_WAKE
) (
  input  logic clk,
  input  logic rstN,
  input  logic sessReqN,
  input  logic modeNormal,
  input  logic rstReq,
  input  logic cardPresent,
  input  logic faultOvercurrent,
  input  logic faultOverheat,
  input  logic faultSupplyLow,
  input  logic chipSel,
  input  logic halfTick,
  output logic convEn,
  output logic supplyEn,
  output logic dataEn,
  output logic clkEn,
  output logic cardRst,
  output logic irqLowEn
);

  strobes_t stb;
  logic effReqN, effMode, effRstReq, faultAny, irqPend;

  scs_ctrl #(
    .SUP_ON(SUP_ON), .IO_ON(IO_ON), .RST_ON(RST_ON),
    .CLK_OFF(CLK_OFF), .IO_OFF(IO_OFF), .SUP_OFF(SUP_OFF),
    .CONV_OFF(CONV_OFF), .WAKE_TICKS(WAKE_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .effReqN(effReqN), .effMode(effMode), .effRstReq(effRstReq),
    .faultAny(faultAny), .cardPresent(cardPresent), .irqPend(irqPend),
    .halfTick(halfTick), .stb(stb)
  );

  scs_dp u_dp (
    .clk(clk), .rstN(rstN),
    .sessReqN(sessReqN), .modeNormal(modeNormal), .rstReq(rstReq),
    .chipSel(chipSel), .cardPresent(cardPresent),
    .faultOvercurrent(faultOvercurrent), .faultOverheat(faultOverheat),
    .faultSupplyLow(faultSupplyLow), .stb(stb),
    .effReqN(effReqN), .effMode(effMode), .effRstReq(effRstReq),
    .faultAny(faultAny), .irqPend(irqPend),
    .convEn(convEn), .supplyEn(supplyEn), .dataEn(dataEn),
    .clkEn(clkEn), .cardRst(cardRst), .irqLowEn(irqLowEn)
  );

endmodule

// File: tb/card_session_seq_tb.sv
`timescale 1ns/1ps
module card_session_seq_tb;

  localparam int WAKE = 96;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sessReqN = 1'b1, modeNormal = 1'b1, rstReq = 1'b0, cardPresent = 1'b1;
  logic faultOvercurrent = 1'b0, faultOverheat = 1'b0, faultSupplyLow = 1'b0;
  logic chipSel = 1'b1, halfTick = 1'b0;
  logic convEn, supplyEn, dataEn, clkEn, cardRst, irqLowEn;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  card_session_seq u_dut (
    .clk(clk), .rstN(rstN), .sessReqN(sessReqN), .modeNormal(modeNormal),
    .rstReq(rstReq), .cardPresent(cardPresent),
    .faultOvercurrent(faultOvercurrent), .faultOverheat(faultOverheat),
    .faultSupplyLow(faultSupplyLow), .chipSel(chipSel), .halfTick(halfTick),
    .convEn(convEn), .supplyEn(supplyEn), .dataEn(dataEn), .clkEn(clkEn),
    .cardRst(cardRst), .irqLowEn(irqLowEn)
  );

  // half-period pulse every 4 clocks
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    halfTick = (tdiv == 0);
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 sleep, 2 power-up, 3 live, 4 shutdown, 5 fault shutdown
  int  mPhase = 0, mHalf = 0, mWake = 0;
  bit  mConv = 0, mSup = 0, mData = 0, mClk = 0, mArmed = 0, mRst = 0, mIrq = 0;
  bit  kReqN = 1, kMode = 1, kRr = 0;

  task automatic modelEdge();
    bit eReqN, eMode, eRr, bad;
    if (!rstN) begin
      mPhase = 0; mHalf = 0; mWake = 0;
      {mConv, mSup, mData, mClk, mArmed, mRst, mIrq} = '0;
      kReqN = 1; kMode = 1; kRr = 0;
      return;
    end
    eReqN = chipSel ? sessReqN : kReqN;
    eMode = chipSel ? modeNormal : kMode;
    eRr   = chipSel ? rstReq : kRr;
    bad   = faultOvercurrent || faultOverheat || faultSupplyLow || !cardPresent;
    if (chipSel) begin kReqN = sessReqN; kMode = modeNormal; kRr = rstReq; end
    if ((mPhase == 0 || mPhase == 1) && eReqN && cardPresent) mIrq = 0;
    if (mPhase == 0) begin
      if (!eMode) begin mPhase = 1; mWake = 0; end
      else if (!eReqN && !mIrq) begin mPhase = 2; mHalf = 0; mConv = 1; end
    end else if (mPhase == 1) begin
      if (!eMode) mWake = 0;
      else if (halfTick) begin mWake++; if (mWake == WAKE) mPhase = 0; end
    end else if (mPhase == 2 || mPhase == 3) begin
      if (bad) begin mIrq = 1; mPhase = 5; mHalf = 0; mArmed = 0; end
      else if (eReqN || !eMode) begin mPhase = 4; mHalf = 0; mArmed = 0; end
      else if (mPhase == 2) begin
        if (mHalf >= 8 && eRr) mClk = 1;
        if (halfTick) begin
          mHalf++;
          if (mHalf == 3) mSup = 1;
          if (mHalf == 8) mData = 1;
          if (mHalf == 14) begin mArmed = 1; mPhase = 3; end
        end
      end
    end else begin
      if (halfTick) begin
        mHalf++;
        if (mHalf == 1) mClk = 0;
        if (mHalf == 2) mData = 0;
        if (mHalf == 3) mSup = 0;
        if (mHalf == 10) begin
          mConv = 0; mWake = 0;
          mPhase = (mPhase == 4 && !eMode) ? 1 : 0;
        end
      end
    end
    mRst = mArmed ? !eRr : 1'b0;
  endtask

  always @(posedge clk) begin
    modelEdge();
    #2;
    if (!done) begin
      chk("R2", "convEn vs model", convEn, mConv);
      chk("R3", "supplyEn vs model", supplyEn, mSup);
      chk("R3", "dataEn vs model", dataEn, mData);
      chk("R4", "clkEn vs model", clkEn, mClk);
      chk("R5", "cardRst vs model", cardRst, mRst);
      chk("R9", "irqLowEn vs model", irqLowEn, mIrq & chipSel);
    end
  end

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    finishRun();
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    // R1 reset state
    chk("R1", "convEn", convEn, 1'b0);
    chk("R1", "supplyEn", supplyEn, 1'b0);
    chk("R1", "dataEn", dataEn, 1'b0);
    chk("R1", "clkEn", clkEn, 1'b0);
    chk("R1", "cardRst", cardRst, 1'b0);
    chk("R1", "irqLowEn", irqLowEn, 1'b0);

    // power-up with clock window
    sessReqN = 1'b0;
    waitCyc(2);
    chk("R2", "convEn after request", convEn, 1'b1);
    waitCyc(34);
    rstReq = 1'b1;
    waitCyc(2);
    chk("R4", "clkEn in window", clkEn, 1'b1);
    waitCyc(30);
    chk("R3", "dataEn live", dataEn, 1'b1);
    rstReq = 1'b0;
    waitCyc(2);
    chk("R5", "cardRst inverse of low", cardRst, 1'b1);
    rstReq = 1'b1;
    waitCyc(2);
    chk("R5", "cardRst inverse of high", cardRst, 1'b0);
    chk("R4", "clkEn unaffected after arm", clkEn, 1'b1);
    rstReq = 1'b0;
    waitCyc(2);

    // normal shutdown
    sessReqN = 1'b1;
    waitCyc(1);
    chk("R6", "cardRst drops at entry", cardRst, 1'b0);
    waitCyc(50);
    chk("R6", "convEn off", convEn, 1'b0);
    chk("R6", "supplyEn off", supplyEn, 1'b0);
    chk("R6", "clkEn off", clkEn, 1'b0);

    // restart, then request again during shutdown
    sessReqN = 1'b0;
    waitCyc(70);
    sessReqN = 1'b1;
    waitCyc(8);
    sessReqN = 1'b0;
    waitCyc(12);
    chk("R11", "supply still falls", supplyEn, 1'b0);
    chk("R11", "converter still on", convEn, 1'b1);
    waitCyc(70);
    chk("R11", "new session after idle", dataEn, 1'b1);
    waitCyc(10);

    // sleep path
    modeNormal = 1'b0;
    waitCyc(50);
    chk("R7", "off after sleep shutdown", convEn, 1'b0);
    waitCyc(20);
    chk("R2", "no start while sleeping", convEn, 1'b0);
    modeNormal = 1'b1;
    waitCyc(200);
    chk("R7", "still waking", convEn, 1'b0);
    waitCyc(220);
    chk("R7", "session after wake", convEn, 1'b1);
    waitCyc(70);

    // fault while live
    faultOverheat = 1'b1;
    waitCyc(1);
    faultOverheat = 1'b0;
    waitCyc(2);
    chk("R8", "interrupt on fault", irqLowEn, 1'b1);
    waitCyc(50);
    chk("R8", "converter off after fault", convEn, 1'b0);
    waitCyc(20);
    chk("R9", "pending blocks session", convEn, 1'b0);
    chipSel = 1'b0;
    waitCyc(2);
    chk("R10", "interrupt released when deselected", irqLowEn, 1'b0);
    chipSel = 1'b1;
    cardPresent = 1'b0;
    sessReqN = 1'b1;
    waitCyc(3);
    chk("R9", "held while card absent", irqLowEn, 1'b1);
    cardPresent = 1'b1;
    waitCyc(3);
    chk("R9", "cleared with card seated", irqLowEn, 1'b0);

    // frozen inputs while deselected
    chipSel = 1'b0;
    sessReqN = 1'b0;
    waitCyc(20);
    chk("R10", "request ignored while deselected", convEn, 1'b0);
    chipSel = 1'b1;
    waitCyc(3);
    chk("R10", "request seen after select", convEn, 1'b1);

    // card removal during power-up
    waitCyc(20);
    cardPresent = 1'b0;
    waitCyc(2);
    chk("R8", "interrupt on card removal", irqLowEn, 1'b1);
    cardPresent = 1'b1;
    waitCyc(50);
    chk("R8", "off after removal", convEn, 1'b0);
    waitCyc(5);
    finishRun();
  end

endmodule